// File: doc/BRIEF.md
# Leading/Trailing Zero and Set-Bit Counter

This combinational unit counts bits in one source operand. A two-bit select chooses one of three counts. The first is the number of zeros above the highest set bit. The second is the number of zeros below the lowest set bit. The third is the number of set bits. The result leaves the unit as a zero-extended integer that is as wide as the operand.

The operand width is a parameter, 32 or 64. When the width is 64, a word flag limits each count to bits 31..0 and the unit ignores the upper half of the operand. In that mode an all-zero low word gives 32, whereas in full mode an all-zero operand gives the operand width. Internally, both zero counts share one leading-zero priority encoder. For the trailing count the scan vector is fed in bit-reversed. The set-bit count comes from a binary adder tree. Instruction decode and pipeline registers belong to the surrounding datapath.

Top module: `bitcount_unit`

## Requirements
- R1: Select encoding: `kind`=0 gives the leading-zero count, 1 the trailing-zero count, 2 the set-bit count, and 3 gives a result of zero.
- R2: In full mode the leading-zero count is the number of zeros seen scanning down from bit XLEN-1 before the first one; it is 0 when bit XLEN-1 is set.
- R3: The trailing-zero count is the number of zeros seen scanning up from bit 0 before the first one; it is 0 when bit 0 is set.
- R4: In full mode, an all-zero operand gives XLEN for both zero counts.
- R5: With `word_mode`=1 and XLEN=64, both zero counts consider only bits 31..0, the leading scan starts at bit 31, and an all-zero low word gives 32.
- R6: The set-bit count covers all XLEN bits in full mode and only bits 31..0 in word mode.
- R7: In word mode, bits XLEN-1..32 of the operand have no effect on any count.
- R8: The result is zero-extended to XLEN bits and never exceeds XLEN.
- R9: With XLEN=32, `word_mode` has no effect, and every count behaves as in full mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src | input | XLEN | Operand to be counted |
| kind | input | 2 | Count select (0 leading zeros, 1 trailing zeros, 2 set bits, 3 zero) |
| word_mode | input | 1 | Restrict the count to bits 31..0 (only meaningful when XLEN=64) |
| count | output | XLEN | Zero-extended count result |

## Verification
The bench sweeps a single one at every bit position through every select and both modes. This shows a priority encoder that is off by one, or a reversal that is wired the wrong way round, as a wrong count at one end. All-zero operands separate the full-mode answer of 64 from the word-mode answer of 32; a missing clamp would give 64 in word mode. Operands whose upper half is nonzero and whose low word is zero show whether the upper bits leak into word mode: a leak gives a leading count of 0, or a set-bit count that is too large. A second instance with a 32-bit width checks that toggling the word flag changes nothing there, and a pseudo-random sweep covers mixed patterns.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;

    typedef enum logic [1:0] {
        CK_LEAD  = 2'd0,
        CK_TRAIL = 2'd1,
        CK_POP   = 2'd2,
        CK_NONE  = 2'd3
    } cnt_kind_e;

    localparam int unsigned WORD_BITS = 32;

    typedef struct packed {
        cnt_kind_e kind;
        logic      word;
    } cnt_req_t;

    // Limit a word-mode zero count to the word width.
    function automatic logic [7:0] sat_word(input logic [7:0] c);
        return (c > 8'(WORD_BITS)) ? 8'(WORD_BITS) : c;
    endfunction

endpackage

// File: rtl/bcu_scan.sv
module bcu_scan #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src,
    input  logic            trail,
    input  logic            word,
    output logic [XLEN-1:0] vec
);
    logic [XLEN-1:0] full_rev;

    always_comb begin
        for (int i = 0; i < XLEN; i++) full_rev[i] = src[XLEN-1-i];
    end

    generate
        if (XLEN > 32) begin : g_wide
            logic [31:0] lo_rev;
            always_comb begin
                for (int i = 0; i < 32; i++) lo_rev[i] = src[31-i];
                if (word)
                    vec = {(trail ? lo_rev : src[31:0]), {(XLEN-32){1'b0}}};
                else
                    vec = trail ? full_rev : src;
            end
        end else begin : g_narrow
            always_comb vec = trail ? full_rev : src;
        end
    endgenerate
endmodule

// File: rtl/bcu_lead.sv
module bcu_lead #(
    parameter int XLEN = 64,
    localparam int CW = $clog2(XLEN + 1)
) (
    input  logic [XLEN-1:0] vec,
    output logic [CW-1:0]   lz
);
    always_comb begin
        lz = CW'(XLEN);
        for (int i = 0; i < XLEN; i++)
            if (vec[i]) lz = CW'(XLEN - 1 - i);
    end
endmodule

// File: rtl/bcu_pop.sv
module bcu_pop #(
    parameter int XLEN = 64,
    localparam int CW = $clog2(XLEN + 1)
) (
    input  logic [XLEN-1:0] vec,
    output logic [CW-1:0]   ones
);
    logic [CW-1:0] acc [XLEN];

    always_comb begin
        for (int i = 0; i < XLEN; i++) acc[i] = CW'(vec[i]);
        for (int s = XLEN / 2; s >= 1; s = s / 2)
            for (int i = 0; i < s; i++)
                acc[i] = acc[2*i] + acc[2*i+1];
        ones = acc[0];
    end
endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
    import bitcount_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src,
    input  logic [1:0]      kind,
    input  logic            word_mode,
    output logic [XLEN-1:0] count
);
    localparam int CW = $clog2(XLEN + 1);
    localparam bit HAS_WORD = (XLEN > 32);

    cnt_req_t        req;
    logic [XLEN-1:0] scan_vec;
    logic [XLEN-1:0] pop_vec;
    logic [CW-1:0]   lz_raw;
    logic [CW-1:0]   pop_raw;
    logic [7:0]      zcnt;

    assign req.kind = cnt_kind_e'(kind);
    assign req.word = word_mode & HAS_WORD;

    bcu_scan #(.XLEN(XLEN)) u_scan (
        .src   (src),
        .trail (req.kind == CK_TRAIL),
        .word  (req.word),
        .vec   (scan_vec)
    );

    bcu_lead #(.XLEN(XLEN)) u_lead (
        .vec (scan_vec),
        .lz  (lz_raw)
    );

    generate
        if (XLEN > 32) begin : g_popw
            assign pop_vec = req.word ? {{(XLEN-32){1'b0}}, src[31:0]} : src;
        end else begin : g_popn
            assign pop_vec = src;
        end
    endgenerate

    bcu_pop #(.XLEN(XLEN)) u_pop (
        .vec  (pop_vec),
        .ones (pop_raw)
    );

    always_comb begin
        zcnt = req.word ? sat_word(8'(lz_raw)) : 8'(lz_raw);
        unique case (req.kind)
            CK_LEAD, CK_TRAIL: count = XLEN'(zcnt);
            CK_POP:            count = XLEN'(pop_raw);
            default:           count = '0;
        endcase
    end
endmodule

// File: rtl/bitcount_unit_chk.sv
module bitcount_unit_chk #(
    parameter int XLEN = 64
) (
    input logic [XLEN-1:0] src,
    input logic [1:0]      kind,
    input logic            word_mode,
    input logic [XLEN-1:0] count
);
    always_comb begin
        // R8
        count_range_chk: assert (count <= XLEN)
            else $error("count above operand width");
        // R5
        word_range_chk: assert (!(word_mode && XLEN > 32) || count <= 32)
            else $error("word-mode count above 32");
        // R4
        zero_full_chk: assert (!(src == '0 && !word_mode && kind < 2'd2) || count == XLEN)
            else $error("zero operand full count wrong");
        // R2
        top_set_chk: assert (!(src[XLEN-1] && !word_mode && kind == 2'd0) || count == '0)
            else $error("top bit set but leading count nonzero");
        // R3
        low_set_chk: assert (!(src[0] && kind == 2'd1) || count == '0)
            else $error("bit 0 set but trailing count nonzero");
        // R1
        none_kind_chk: assert (kind != 2'd3 || count == '0)
            else $error("select 3 result nonzero");
    end
endmodule

bind bitcount_unit bitcount_unit_chk #(.XLEN(XLEN)) u_chk (
    .src       (src),
    .kind      (kind),
    .word_mode (word_mode),
    .count     (count)
);

// File: tb/sim_bitcount_unit.sv
module sim_bitcount_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic [1:0]  kind = '0;
    logic        word_mode = 1'b0;
    logic [63:0] cnt64;
    logic [31:0] cnt32;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bitcount_unit #(.XLEN(64)) u0 (
        .src(src), .kind(kind), .word_mode(word_mode), .count(cnt64)
    );
    bitcount_unit #(.XLEN(32)) u1 (
        .src(src[31:0]), .kind(kind), .word_mode(word_mode), .count(cnt32)
    );

    function automatic int ref_cnt(logic [63:0] x, int k, bit w, int xl);
        int n = (w && xl > 32) ? 32 : xl;
        int c = 0;
        bit hit = 0;
        case (k)
            0: begin
                for (int i = n - 1; i >= 0; i--) begin
                    if (x[i]) hit = 1;
                    if (!hit) c++;
                end
            end
            1: begin
                for (int i = 0; i < n; i++) begin
                    if (x[i]) hit = 1;
                    if (!hit) c++;
                end
            end
            2: for (int i = 0; i < n; i++) c += int'(x[i]);
            default: c = 0;
        endcase
        return c;
    endfunction

    function automatic string tag_of(int k, bit w, int xl);
        if (k == 3) return "R1";
        if (xl == 32 && w) return "R9";
        if (k == 2) return "R6";
        if (w) return "R5";
        return (k == 0) ? "R2" : "R3";
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d (src=%h kind=%0d word=%0b)",
                     tag, got, exp, src, kind, word_mode);
        end
    endtask

    task automatic apply(logic [63:0] x, int k, bit w, string force_tag);
        @(posedge clk);
        src = x; kind = 2'(k); word_mode = w;
        @(negedge clk);
        chk((force_tag != "") ? force_tag : tag_of(k, w, 64), cnt64,
            64'(ref_cnt(x, k, w, 64)));
        chk((force_tag != "") ? force_tag : tag_of(k, w, 32), {32'd0, cnt32},
            64'(ref_cnt(x, k, w, 32)));
    endtask

    initial begin
        logic [63:0] lfsr = 64'hACE1_2468_1357_BDF9;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: reset-time inputs are all zero, leading count equals width
        chk("R4", cnt64, 64'd64);
        chk("R4", {32'd0, cnt32}, 64'd32);

        for (int p = 0; p < 64; p++)
            for (int k = 0; k < 4; k++)
                for (int w = 0; w < 2; w++)
                    apply(64'd1 << p, k, w[0], "");

        for (int k = 0; k < 4; k++) begin
            apply('0, k, 1'b0, (k < 2) ? "R4" : "");
            apply('0, k, 1'b1, (k < 2) ? "R5" : "");
            apply('1, k, 1'b0, "");
            apply('1, k, 1'b1, "");
            // R7: upper half nonzero, low word zero
            apply(64'hFFFF_FFFF_0000_0000, k, 1'b1, "R7");
            apply(64'h8000_0001_0000_0000, k, 1'b1, "R7");
            apply(64'h8000_0000_0000_0010, k, 1'b1, "R7");
        end

        // R8: full-width result of an all-zero operand stays within width
        apply('0, 0, 1'b0, "R8");

        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            apply(lfsr >> (i % 61), i % 4, i[2], "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule